// File: doc/BRIEF.md
# USB Receive Packet Combiner

This block sits between the receive data path of a USB endpoint and its receive FIFO. Bytes from the wire arrive one per beat, with a start marker on the first byte of each USB data packet and an end marker on the last byte. The block forwards the bytes as FIFO writes. It also decides where one logical FIFO packet ends, so that several USB packets can be joined into a single FIFO packet. When a FIFO packet ends, the block raises a completion strobe and reports the length of that packet.

A 16-bit configuration word sets the rules. Bits [10:0] hold the largest payload of one USB packet. Bits [15:11] hold a multiplier field. The endpoint type, the speed, and two enables select one of three merge modes:

- **Bulk splitting.** Up to 32 full-size packets are joined into one FIFO packet.
- **High-bandwidth.** For high-speed isochronous or interrupt endpoints, the packets of one microframe are joined, at most two or three of them. The next microframe start closes the joined packet.
- **Pass-through.** Every USB packet becomes its own FIFO packet.

The block also compares the payload size times the multiplier against the FIFO capacity, and flags a configuration that does not fit.

Top module: `rx_pkt_merge`

## Requirements
- R1: After reset, wr_en, pkt_done, pkt_len, pkt_ovr and cfg_err are all zero.
- R2: Pass-through mode applies in each of these cases:
  - the endpoint type is control (ep_type 2'b00);
  - the endpoint is isochronous (2'b01) or interrupt (2'b11) at full speed;
  - hibw_en is low on an isochronous or interrupt endpoint;
  - the endpoint is bulk (2'b10) and split_en is low.

  In pass-through mode every USB packet ends its own FIFO packet, and cfg_reg bits [15:11] have no effect.
- R3: In bulk splitting mode (ep_type 2'b10 with split_en high), the multiplier is cfg_reg[15:11] plus one, which allows 1 to 32. pkt_done fires only after that many full-size packets have been received.
- R4: In bulk splitting mode, a packet with fewer bytes than the payload size cfg_reg[10:0] ends the FIFO packet early.
- R5: High-bandwidth mode requires an isochronous or interrupt endpoint with high_speed and hibw_en both high. In this mode, cfg_reg bit 12 selects a multiplier of 3; otherwise bit 11 selects 2; otherwise the multiplier is 1. The FIFO packet closes once that many packets have been received.
- R6: In high-bandwidth mode, a uframe_sof pulse closes an open FIFO packet that holds fewer packets than the multiplier. pkt_done follows in the next cycle.
- R7: Within one USB packet, bytes beyond the payload size are not written. The FIFO packet that contains such a packet reports pkt_ovr high together with pkt_done.
- R8: pkt_len, valid while pkt_done is high, equals the number of bytes written to the FIFO for that FIFO packet.
- R9: cfg_err is high when the payload size times the multiplier exceeds FIFO_BYTES (4096 by default). With dbl_buf high, the limit is half of FIFO_BYTES instead.
- R10: Each accepted byte appears on wr_data with wr_en high one cycle after its input beat. The last write of a FIFO packet coincides with pkt_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a USB packet |
| in_eop | input | 1 | Last byte of a USB packet |
| uframe_sof | input | 1 | Microframe start pulse |
| high_speed | input | 1 | Link runs at high speed |
| ep_type | input | 2 | Endpoint type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| split_en | input | 1 | Bulk packet splitting enabled |
| hibw_en | input | 1 | High-bandwidth periodic transfers enabled |
| dbl_buf | input | 1 | FIFO is used double-buffered |
| cfg_reg | input | 16 | [10:0] payload size, [15:11] multiplier minus one |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 8 | FIFO write byte |
| pkt_done | output | 1 | Combined FIFO packet complete |
| pkt_len | output | 16 | Byte length of the completed FIFO packet |
| pkt_ovr | output | 1 | Completed FIFO packet had a truncated USB packet |
| cfg_err | output | 1 | Combined size exceeds the FIFO limit |

## Verification
The same sequences of equal-length packets are sent in every mode. This separates the three count rules: one per packet in pass-through, the field plus one for bulk, and bits 12 and 11 for high-bandwidth. In pass-through, a large multiplier field is programmed on purpose, to show that it is ignored.

A short packet in bulk mode and an early microframe start in high-bandwidth mode check the two early-close paths. An oversized packet checks truncation and the overrun flag. The multiplier limits are probed at the ends of their ranges: 32 packets in bulk mode, and a combined size exactly at the FIFO capacity, with and without double buffering.

// File: rtl/rx_merge_pkg.sv
// Package: shared types for the receive packet combiner.
// Assumes the endpoint-type code used by standard USB endpoint descriptors.
package rx_merge_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'b00,
        EP_ISO  = 2'b01,
        EP_BULK = 2'b10,
        EP_INTR = 2'b11
    } ep_kind_e;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_SPLIT = 2'b01,
        MODE_HIBW  = 2'b10
    } merge_mode_e;

endpackage

// File: rtl/rx_mode_decode.sv
// Module: rx_mode_decode
// Picks the merge mode and the effective multiplier from the endpoint
// type, speed, enables and the multiplier field.
// Assumes the configuration is held stable while a packet is open.
module rx_mode_decode
    import rx_merge_pkg::*;
#(
    parameter int MULT_W = 5,
    localparam int MC_W  = MULT_W + 1
) (
    input  logic [1:0]       ep_type,
    input  logic             high_speed,
    input  logic             split_en,
    input  logic             hibw_en,
    input  logic [MULT_W-1:0] mult_field,
    output merge_mode_e      mode,
    output logic [MC_W-1:0]  mult
);

    ep_kind_e kind;
    assign kind = ep_kind_e'(ep_type);

    // Select the mode and derive the multiplier for it.
    always_comb begin
        mode = MODE_PASS;
        mult = MC_W'(1);
        if (kind == EP_BULK && split_en) begin
            mode = MODE_SPLIT;
            mult = {1'b0, mult_field} + MC_W'(1);
        end else if ((kind == EP_ISO || kind == EP_INTR) && high_speed && hibw_en) begin
            mode = MODE_HIBW;
            if (mult_field[1])      mult = MC_W'(3);
            else if (mult_field[0]) mult = MC_W'(2);
        end
    end

endmodule

// File: rtl/rx_size_check.sv
// Module: rx_size_check
// Flags a payload size times multiplier that does not fit the receive
// FIFO, or half of it when the FIFO is double-buffered.
// Assumes FIFO_BYTES fits in PROD_W bits.
module rx_size_check #(
    parameter int MAXP_W     = 11,
    parameter int MC_W       = 6,
    parameter int FIFO_BYTES = 4096,
    localparam int PROD_W    = MAXP_W + MC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MAXP_W-1:0] maxp,
    input  logic [MC_W-1:0]   mult,
    input  logic              dbl_buf,
    output logic              cfg_err
);

    localparam logic [PROD_W-1:0] LIM_FULL = PROD_W'(FIFO_BYTES);
    localparam logic [PROD_W-1:0] LIM_HALF = PROD_W'(FIFO_BYTES / 2);

    logic [PROD_W-1:0] total;
    assign total = PROD_W'(maxp) * PROD_W'(mult);

    // Register the comparison of the combined size against the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= total > (dbl_buf ? LIM_HALF : LIM_FULL);
    end

endmodule

// File: rtl/rx_byte_gate.sv
// Module: rx_byte_gate
// Counts the bytes of the current USB packet and accepts only the first
// maxp of them. Reports truncation and a short final byte count.
// Assumes one byte per beat and no zero-length packets.
module rx_byte_gate #(
    parameter int MAXP_W = 11,
    localparam int CNT_W = MAXP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [MAXP_W-1:0] maxp,
    output logic              accept,
    output logic              trunc,
    output logic              last,
    output logic              short_end
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] got;

    assign idx       = in_sop ? '0 : cnt;
    assign accept    = in_valid && (idx < {1'b0, maxp});
    assign trunc     = in_valid && !accept;
    assign got       = idx + CNT_W'(accept);
    assign last      = in_valid && in_eop;
    assign short_end = last && (got < {1'b0, maxp});

    // Track the accepted byte count within the current packet.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (last)     cnt <= '0;
        else if (in_valid) cnt <= got;
    end

endmodule

// File: rtl/rx_pkt_merge.sv
// Module: rx_pkt_merge (top)
// Joins consecutive USB packets into one FIFO packet by mode and
// multiplier. Writes accepted bytes one cycle later and strobes pkt_done
// with the total length.
// Assumes uframe_sof never falls inside a packet and the configuration
// changes only while no FIFO packet is open.
module rx_pkt_merge
    import rx_merge_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int MAXP_W     = 11,
    parameter int MULT_W     = 5,
    parameter int FIFO_BYTES = 4096,
    localparam int CFG_W     = MAXP_W + MULT_W,
    localparam int MC_W      = MULT_W + 1,
    localparam int LEN_W     = MAXP_W + MULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              uframe_sof,
    input  logic              high_speed,
    input  logic [1:0]        ep_type,
    input  logic              split_en,
    input  logic              hibw_en,
    input  logic              dbl_buf,
    input  logic [CFG_W-1:0]  cfg_reg,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              pkt_done,
    output logic [LEN_W-1:0]  pkt_len,
    output logic              pkt_ovr,
    output logic              cfg_err
);

    logic [MAXP_W-1:0] maxp;
    logic [MULT_W-1:0] mult_field;
    merge_mode_e       mode;
    logic [MC_W-1:0]   mult;
    logic              accept, trunc, last, short_end;
    logic [MC_W-1:0]   pkt_cnt;
    logic [LEN_W-1:0]  len_acc;
    logic              ovr_acc;
    logic              cnt_hit, close_eop, close_sof, close_now;
    logic [LEN_W-1:0]  len_next;

    assign maxp       = cfg_reg[MAXP_W-1:0];
    assign mult_field = cfg_reg[CFG_W-1:MAXP_W];

    rx_mode_decode #(.MULT_W(MULT_W)) u_mode (
        .ep_type    (ep_type),
        .high_speed (high_speed),
        .split_en   (split_en),
        .hibw_en    (hibw_en),
        .mult_field (mult_field),
        .mode       (mode),
        .mult       (mult)
    );

    rx_size_check #(.MAXP_W(MAXP_W), .MC_W(MC_W), .FIFO_BYTES(FIFO_BYTES)) u_size (
        .clk     (clk),
        .rst_n   (rst_n),
        .maxp    (maxp),
        .mult    (mult),
        .dbl_buf (dbl_buf),
        .cfg_err (cfg_err)
    );

    rx_byte_gate #(.MAXP_W(MAXP_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .maxp      (maxp),
        .accept    (accept),
        .trunc     (trunc),
        .last      (last),
        .short_end (short_end)
    );

    assign cnt_hit   = (pkt_cnt + MC_W'(1)) >= mult;
    assign close_eop = last && (mode == MODE_PASS || cnt_hit ||
                                (mode == MODE_SPLIT && short_end));
    assign close_sof = uframe_sof && mode == MODE_HIBW && (pkt_cnt != '0 || last);
    assign close_now = close_eop || close_sof;
    assign len_next  = len_acc + LEN_W'(accept);

    // Forward accepted bytes to the FIFO one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en   <= accept;
            wr_data <= in_data;
        end
    end

    // Accumulate the packet count, length and overrun; close on a rule hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_cnt  <= '0;
            len_acc  <= '0;
            ovr_acc  <= 1'b0;
            pkt_done <= 1'b0;
            pkt_len  <= '0;
            pkt_ovr  <= 1'b0;
        end else begin
            pkt_done <= close_now;
            if (close_now) begin
                pkt_len <= len_next;
                pkt_ovr <= ovr_acc | trunc;
                pkt_cnt <= '0;
                len_acc <= '0;
                ovr_acc <= 1'b0;
            end else begin
                len_acc <= len_next;
                ovr_acc <= ovr_acc | trunc;
                if (last) pkt_cnt <= pkt_cnt + MC_W'(1);
            end
        end
    end

endmodule

// File: rtl/rx_pkt_merge_chk.sv
// Module: rx_pkt_merge_chk
// Timing and bound properties of the combiner, bound to the top module.
// Assumes configuration changes only while no packet is open.
module rx_pkt_merge_chk
    import rx_merge_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_eop,
    input logic        uframe_sof,
    input logic        wr_en,
    input logic        pkt_done,
    input logic        cfg_err,
    input logic [15:0] cfg_reg,
    input merge_mode_e mode,
    input logic [5:0]  mult,
    input logic [5:0]  pkt_cnt
);

    // R10: a write is always caused by an input beat one cycle earlier.
    p_wr_after_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    // R2: in pass-through mode every packet end closes a FIFO packet.
    p_pass_close_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PASS && in_valid && in_eop) |=> pkt_done);

    // R3: the open packet count stays below the multiplier.
    p_count_below_mult_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_cnt < mult);

    // R6: a microframe start closes an open high-bandwidth packet.
    p_sof_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HIBW && uframe_sof && pkt_cnt != 6'd0) |=> pkt_done);

    // R9: a zero payload size never raises the size error.
    p_zero_size_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reg[10:0] == 11'd0) |=> !cfg_err);

endmodule

bind rx_pkt_merge rx_pkt_merge_chk u_rx_pkt_merge_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_eop     (in_eop),
    .uframe_sof (uframe_sof),
    .wr_en      (wr_en),
    .pkt_done   (pkt_done),
    .cfg_err    (cfg_err),
    .cfg_reg    (cfg_reg),
    .mode       (mode),
    .mult       (mult),
    .pkt_cnt    (pkt_cnt)
);

// File: tb/rx_pkt_merge_bench.sv
`timescale 1ns/1ps
module rx_pkt_merge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        uframe_sof = 1'b0;
    logic        high_speed = 1'b0;
    logic [1:0]  ep_type = 2'b00;
    logic        split_en = 1'b0;
    logic        hibw_en = 1'b0;
    logic        dbl_buf = 1'b0;
    logic [15:0] cfg_reg = '0;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        pkt_done;
    logic [15:0] pkt_len;
    logic        pkt_ovr;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int n_done = 0;
    int lens [0:63];
    logic ovrs [0:63];
    logic [7:0] first_byte;

    always #4 clk = ~clk;

    rx_pkt_merge u_rx_pkt_merge (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .uframe_sof(uframe_sof),
        .high_speed(high_speed), .ep_type(ep_type), .split_en(split_en),
        .hibw_en(hibw_en), .dbl_buf(dbl_buf), .cfg_reg(cfg_reg),
        .wr_en(wr_en), .wr_data(wr_data), .pkt_done(pkt_done),
        .pkt_len(pkt_len), .pkt_ovr(pkt_ovr), .cfg_err(cfg_err)
    );

    // Monitor: record writes and completed FIFO packets.
    always @(negedge clk) begin
        if (wr_en) begin
            if (wr_cnt == 0) first_byte = wr_data;
            wr_cnt = wr_cnt + 1;
        end
        if (pkt_done && n_done < 64) begin
            lens[n_done] = pkt_len;
            ovrs[n_done] = pkt_ovr;
            n_done = n_done + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        wr_cnt = 0;
        n_done = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(base + i);
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] t, input logic hs, input logic sp,
                            input logic hb, input logic [15:0] c);
        ep_type = t; high_speed = hs; split_en = sp; hibw_en = hb; cfg_reg = c;
        dbl_buf = 1'b0;
        idle(2);
        clear_mon();
    endtask

    task automatic t_reset();
        chk(wr_en == 1'b0,    "R1 wr_en",    wr_en,    0);
        chk(pkt_done == 1'b0, "R1 pkt_done", pkt_done, 0);
        chk(pkt_len == 16'd0, "R1 pkt_len",  pkt_len,  0);
        chk(pkt_ovr == 1'b0,  "R1 pkt_ovr",  pkt_ovr,  0);
        chk(cfg_err == 1'b0,  "R1 cfg_err",  cfg_err,  0);
    endtask

    task automatic t_pass();
        // R2: full-speed iso with bit 11 set: one FIFO packet per USB packet.
        set_mode(2'b01, 1'b0, 1'b0, 1'b1, {5'b00001, 11'd8});
        send_pkt(8, 0); send_pkt(8, 8); idle(3);
        chk(n_done == 2, "R2 fs iso count", n_done, 2);
        chk(lens[0] == 8 && lens[1] == 8, "R2 fs iso len", lens[1], 8);
        // R2: bulk without splitting ignores a large multiplier field.
        set_mode(2'b10, 1'b1, 1'b0, 1'b0, {5'b00011, 11'd4});
        send_pkt(4, 0); send_pkt(4, 4); send_pkt(4, 8); idle(3);
        chk(n_done == 3, "R2 bulk no split count", n_done, 3);
        // R2: control endpoint ignores the multiplier field as well.
        set_mode(2'b00, 1'b1, 1'b1, 1'b1, {5'b00010, 11'd4});
        send_pkt(4, 0); send_pkt(4, 4); idle(3);
        chk(n_done == 2, "R2 control count", n_done, 2);
    endtask

    task automatic t_split();
        // R3: field 2 gives a multiplier of 3.
        set_mode(2'b10, 1'b1, 1'b1, 1'b0, {5'd2, 11'd4});
        send_pkt(4, 0); send_pkt(4, 4); idle(3);
        chk(n_done == 0, "R3 open after 2 of 3", n_done, 0);
        send_pkt(4, 8); idle(3);
        chk(n_done == 1, "R3 close after 3", n_done, 1);
        chk(lens[0] == 12, "R8 len of 3x4", lens[0], 12);
        // R3: field 31 gives the maximum multiplier of 32.
        set_mode(2'b10, 1'b1, 1'b1, 1'b0, {5'd31, 11'd2});
        for (int p = 0; p < 31; p++) send_pkt(2, 2 * p);
        idle(3);
        chk(n_done == 0, "R3 open after 31 of 32", n_done, 0);
        send_pkt(2, 62); idle(3);
        chk(n_done == 1, "R3 close after 32", n_done, 1);
        chk(lens[0] == 64, "R8 len of 32x2", lens[0], 64);
    endtask

    task automatic t_short();
        // R4: a short packet ends the bulk FIFO packet early.
        set_mode(2'b10, 1'b1, 1'b1, 1'b0, {5'd3, 11'd4});
        send_pkt(4, 0); send_pkt(2, 4); idle(3);
        chk(n_done == 1, "R4 short close count", n_done, 1);
        chk(lens[0] == 6, "R4 short close len", lens[0], 6);
    endtask

    task automatic t_hibw();
        // R5: bit 11 gives 2 packets per FIFO packet.
        set_mode(2'b01, 1'b1, 1'b0, 1'b1, {5'b00001, 11'd8});
        send_pkt(8, 0); idle(2);
        chk(n_done == 0, "R5 bit11 open after 1", n_done, 0);
        send_pkt(8, 8); idle(3);
        chk(n_done == 1 && lens[0] == 16, "R5 bit11 len", lens[0], 16);
        // R5: bit 12 gives 3 packets per FIFO packet on an interrupt endpoint.
        set_mode(2'b11, 1'b1, 1'b0, 1'b1, {5'b00010, 11'd8});
        send_pkt(8, 0); send_pkt(8, 8); idle(2);
        chk(n_done == 0, "R5 bit12 open after 2", n_done, 0);
        send_pkt(8, 16); idle(3);
        chk(n_done == 1 && lens[0] == 24, "R5 bit12 len", lens[0], 24);
    endtask

    task automatic t_sof();
        // R6: a microframe start closes a partly filled packet.
        set_mode(2'b01, 1'b1, 1'b0, 1'b1, {5'b00010, 11'd8});
        send_pkt(8, 0); idle(2);
        @(negedge clk); uframe_sof = 1'b1;
        @(negedge clk); uframe_sof = 1'b0;
        chk(pkt_done == 1'b1, "R6 done after sof", pkt_done, 1);
        idle(2);
        chk(n_done == 1 && lens[0] == 8, "R6 sof len", lens[0], 8);
        // R6: a microframe start with nothing open produces no packet.
        clear_mon();
        @(negedge clk); uframe_sof = 1'b1;
        @(negedge clk); uframe_sof = 1'b0;
        idle(2);
        chk(n_done == 0, "R6 idle sof", n_done, 0);
    endtask

    task automatic t_trunc();
        // R7: 6 bytes against a payload of 4 are cut to 4 and flag overrun.
        set_mode(2'b00, 1'b0, 1'b0, 1'b0, {5'd0, 11'd4});
        send_pkt(6, 100); idle(3);
        chk(wr_cnt == 4, "R7 bytes written", wr_cnt, 4);
        chk(n_done == 1 && ovrs[0] == 1'b1, "R7 overrun flag", int'(ovrs[0]), 1);
        chk(lens[0] == 4, "R8 truncated len", lens[0], 4);
        clear_mon();
        send_pkt(3, 0); idle(3);
        chk(ovrs[0] == 1'b0, "R7 no overrun on fit", int'(ovrs[0]), 0);
    endtask

    task automatic t_timing();
        // R10: one beat in, a write with the same byte one cycle later.
        set_mode(2'b00, 1'b0, 1'b0, 1'b0, {5'd0, 11'd4});
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'h5A; in_sop = 1'b1; in_eop = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        chk(wr_en == 1'b1 && wr_data == 8'h5A, "R10 write delay", int'(wr_data), 'h5A);
        chk(pkt_done == 1'b1, "R10 done with last write", pkt_done, 1);
        chk(first_byte == 8'h5A || wr_cnt == 0, "R10 data order", int'(first_byte), 'h5A);
    endtask

    task automatic t_size();
        // R9: 1024 x 4 equals 4096, which fits the full FIFO.
        set_mode(2'b10, 1'b1, 1'b1, 1'b0, {5'd3, 11'd1024});
        idle(2);
        chk(cfg_err == 1'b0, "R9 exact fit", cfg_err, 0);
        dbl_buf = 1'b1; idle(2);
        chk(cfg_err == 1'b1, "R9 double buffer limit", cfg_err, 1);
        // R9: 1024 x 5 exceeds the full FIFO.
        dbl_buf = 1'b0; cfg_reg = {5'd4, 11'd1024}; idle(2);
        chk(cfg_err == 1'b1, "R9 over full", cfg_err, 1);
        // R9: high-bandwidth 1024 x 3 fits single but not double buffered.
        set_mode(2'b01, 1'b1, 1'b0, 1'b1, {5'b00010, 11'd1024});
        idle(2);
        chk(cfg_err == 1'b0, "R9 hibw fits", cfg_err, 0);
        dbl_buf = 1'b1; idle(2);
        chk(cfg_err == 1'b1, "R9 hibw double", cfg_err, 1);
        dbl_buf = 1'b0; cfg_reg = '0; idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_split();
        t_short();
        t_hibw();
        t_sof();
        t_trunc();
        t_timing();
        t_size();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule